// File: doc/BRIEF.md
# Bridge Transaction Ordering Arbiter

This block decides, for one direction of a bus bridge, which queued transaction may be started next on the outbound bus. Two sources compete: the head of a posted-write FIFO, and a small set of delayed-transaction slots. Each slot holds a retried request or a completion that is waiting to go out. Every transaction accepted on the inbound bus takes a sequence tag from a tag allocator inside the block. The arbiter compares tags modulo the tag width and holds back read requests, write requests and read completions while a posted write accepted earlier is still queued. Write completions and posted writes are never held back in this way.

When the posted head and at least one eligible delayed slot are both waiting, the two sides take turns. This keeps posted writes able to pass stalled delayed traffic, and it keeps delayed traffic from starving. Delayed slots are independent of one another, so eligible slots are served with a rotating priority. The grant outputs are combinational permissions. The consumer pulses `launch` in the cycle it actually takes the granted transaction, and only then do the fairness and rotation states advance. A separate output says when the granted delayed slot is a read completion whose data may now be returned to the initiator.

Top module: `xbr_order_arb`

## Requirements
- R1: After a synchronous reset with `rst_n` low, the tag allocator is 0, posted writes win the first contested cycle, and delayed rotation starts at slot 0. With no valid input, all grants and `rd_release` are low.
- R2: `acc_tag` shows the tag for the next accepted transaction. It increases by one, modulo 2^TAG_W, on each clock edge where `acc_en` is high, and it is unchanged otherwise. It depends on no delayed-slot input.
- R3: A slot with kind 2'b00 (read request) is not eligible while `pw_vld` is high and the posted tag is older. Tag a is older than tag b when (a − b) mod 2^TAG_W has its top bit set.
- R4: A slot with kind 2'b01 (write request) obeys the same restriction as R3.
- R5: A slot with kind 2'b10 (read completion) obeys the same restriction as R3. `rd_release` is high exactly when the granted delayed slot has kind 2'b10.
- R6: A slot with kind 2'b11 (write completion) is eligible whenever it is valid, whatever the posted tag.
- R7: At most one grant is high in any cycle, and only to a valid, eligible source. Whenever `pw_vld` is high, some grant is high.
- R8: When the posted head and an eligible delayed slot are both present, the side that was not served by the most recent launch is granted. The fairness state changes only in a cycle where `launch` is high.
- R9: Among eligible delayed slots, the search starts at the slot after the last launched delayed slot and wraps around. Slot i uses `dly_tag[i*TAG_W +: TAG_W]` and `dly_kind[2*i +: 2]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_en | input | 1 | A transaction is accepted on the inbound bus this cycle |
| acc_tag | output | TAG_W | Sequence tag given to the transaction being accepted |
| pw_vld | input | 1 | The posted-write FIFO head is present |
| pw_tag | input | TAG_W | Sequence tag of the posted-write head |
| dly_vld | input | N_DLY | Per-slot valid flags of the delayed slots |
| dly_tag | input | N_DLY*TAG_W | Per-slot sequence tags, packed flat |
| dly_kind | input | 2*N_DLY | Per-slot kind codes, packed flat |
| launch | input | 1 | The current grant is taken this cycle |
| gnt_pw | output | 1 | The posted-write head may start |
| gnt_dly | output | N_DLY | One-hot grant to a delayed slot |
| rd_release | output | 1 | The granted slot is a read completion whose data may go to the initiator |

## Verification
The ordering holds are the hardest behaviour to see at the ports. A posted write is always eligible and, in the reset fairness state, wins any contest, so a blocked delayed slot and an eligible one look the same from outside. The stimulus first launches a single posted write so that the fairness state favours the delayed side. It then walks the vector table with `launch` held low, so that every vector sees that same state, and a delayed grant appears exactly when the slot is allowed past the posted head. This includes tag pairs that straddle the wrap point.

// File: rtl/xbr_order_pkg.sv
// Shared types for the bridge ordering arbiter.
package xbr_order_pkg;

    // Kind of a delayed-slot entry; the codes are part of the port contract.
    typedef enum logic [1:0] {
        DK_RD_REQ = 2'b00,
        DK_WR_REQ = 2'b01,
        DK_RD_CPL = 2'b10,
        DK_WR_CPL = 2'b11
    } dly_kind_e;

endpackage

// File: rtl/xbr_tag_alloc.sv
// Sequence-tag allocator: hands out one incrementing tag per accepted
// transaction. Assumes fewer than 2^(TAG_W-1) transactions are in flight,
// so that comparisons modulo the tag width stay unambiguous.
module xbr_tag_alloc #(
    parameter int TAG_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_en,
    output logic [TAG_W-1:0] tag_o
);

    logic [TAG_W-1:0] tag_q;

    // Advance the tag once per accepted transaction.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tag_q <= '0;
        else if (acc_en)
            tag_q <= tag_q + TAG_W'(1);
    end

    assign tag_o = tag_q;

endmodule

// File: rtl/xbr_dly_elig.sv
// Per-slot ordering filter: a delayed slot is eligible unless a posted
// write with an older tag is still queued. Write completions are exempt.
// Assumes the posted FIFO head is its oldest entry.
module xbr_dly_elig
    import xbr_order_pkg::*;
#(
    parameter int N_DLY = 4,
    parameter int TAG_W = 4
) (
    input  logic                   pw_vld,
    input  logic [TAG_W-1:0]       pw_tag,
    input  logic [N_DLY-1:0]       dly_vld,
    input  logic [N_DLY*TAG_W-1:0] dly_tag,
    input  logic [2*N_DLY-1:0]     dly_kind,
    output logic [N_DLY-1:0]       elig,
    output logic [N_DLY-1:0]       is_rcpl
);

    for (genvar i = 0; i < N_DLY; i++) begin : g_slot
        dly_kind_e        kind;
        logic [TAG_W-1:0] age;
        logic             pw_older;

        // Decode the slot fields and compare its age with the posted head.
        always_comb begin
            kind       = dly_kind_e'(dly_kind[2*i +: 2]);
            age        = pw_tag - dly_tag[i*TAG_W +: TAG_W];
            pw_older   = pw_vld & age[TAG_W-1];
            elig[i]    = dly_vld[i] & ((kind == DK_WR_CPL) | ~pw_older);
            is_rcpl[i] = (kind == DK_RD_CPL);
        end
    end

endmodule

// File: rtl/xbr_rr_pick.sv
// Rotating-priority picker over the delayed slots. The search starts at
// the slot after the last one taken. Assumes N_DLY >= 2.
module xbr_rr_pick #(
    parameter int N_DLY = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_DLY-1:0] req,
    input  logic             advance,
    output logic [N_DLY-1:0] gnt
);

    localparam int PW = (N_DLY > 1) ? $clog2(N_DLY) : 1;

    logic [PW-1:0] ptr_q;
    logic [PW-1:0] sel_idx;
    logic          found;

    // Pick the first requesting slot at or after the pointer, wrapping.
    always_comb begin
        gnt     = '0;
        sel_idx = '0;
        found   = 1'b0;
        for (int k = 0; k < N_DLY; k++) begin
            logic [PW:0] pos;
            pos = {1'b0, ptr_q} + (PW+1)'(k);
            if (pos >= (PW+1)'(N_DLY))
                pos = pos - (PW+1)'(N_DLY);
            if (!found && req[pos[PW-1:0]]) begin
                gnt[pos[PW-1:0]] = 1'b1;
                sel_idx          = pos[PW-1:0];
                found            = 1'b1;
            end
        end
    end

    // Move the pointer past the slot that was taken.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr_q <= '0;
        else if (advance && found)
            ptr_q <= (sel_idx == PW'(N_DLY-1)) ? '0 : sel_idx + PW'(1);
    end

endmodule

// File: rtl/xbr_order_arb.sv
// Ordering arbiter for one bridge direction. It grants either the
// posted-write head or one delayed slot, enforcing the posted-write
// push/pull ordering, with alternating fairness between the two sides.
// Assumes the consumer raises launch only in a cycle where it takes the
// grant currently shown.
module xbr_order_arb
    import xbr_order_pkg::*;
#(
    parameter int N_DLY = 4,
    parameter int TAG_W = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   acc_en,
    output logic [TAG_W-1:0]       acc_tag,
    input  logic                   pw_vld,
    input  logic [TAG_W-1:0]       pw_tag,
    input  logic [N_DLY-1:0]       dly_vld,
    input  logic [N_DLY*TAG_W-1:0] dly_tag,
    input  logic [2*N_DLY-1:0]     dly_kind,
    input  logic                   launch,
    output logic                   gnt_pw,
    output logic [N_DLY-1:0]       gnt_dly,
    output logic                   rd_release
);

    logic [N_DLY-1:0] elig;
    logic [N_DLY-1:0] is_rcpl;
    logic [N_DLY-1:0] pick;
    logic             take_dly;
    logic             last_pw_q;

    xbr_tag_alloc #(.TAG_W(TAG_W)) u_tag (
        .clk    (clk),
        .rst_n  (rst_n),
        .acc_en (acc_en),
        .tag_o  (acc_tag)
    );

    xbr_dly_elig #(.N_DLY(N_DLY), .TAG_W(TAG_W)) u_elig (
        .pw_vld   (pw_vld),
        .pw_tag   (pw_tag),
        .dly_vld  (dly_vld),
        .dly_tag  (dly_tag),
        .dly_kind (dly_kind),
        .elig     (elig),
        .is_rcpl  (is_rcpl)
    );

    xbr_rr_pick #(.N_DLY(N_DLY)) u_pick (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (elig),
        .advance (launch && take_dly),
        .gnt     (pick)
    );

    // Choose the side: delayed only if eligible and it is its turn or posted is absent.
    always_comb begin
        take_dly   = (|pick) && (!pw_vld || last_pw_q);
        gnt_dly    = take_dly ? pick : '0;
        gnt_pw     = pw_vld && !take_dly;
        rd_release = |(gnt_dly & is_rcpl);
    end

    // Remember which side the most recent launch served.
    always_ff @(posedge clk) begin
        if (!rst_n)
            last_pw_q <= 1'b0;
        else if (launch && (gnt_pw || take_dly))
            last_pw_q <= gnt_pw;
    end

endmodule

// File: rtl/xbr_order_arb_chk.sv
// Property checker for the ordering arbiter, attached by bind.
module xbr_order_arb_chk #(
    parameter int N_DLY = 4,
    parameter int TAG_W = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   acc_en,
    input logic [TAG_W-1:0]       acc_tag,
    input logic                   pw_vld,
    input logic [TAG_W-1:0]       pw_tag,
    input logic [N_DLY-1:0]       dly_vld,
    input logic [N_DLY*TAG_W-1:0] dly_tag,
    input logic [2*N_DLY-1:0]     dly_kind,
    input logic                   gnt_pw,
    input logic [N_DLY-1:0]       gnt_dly,
    input logic                   rd_release
);

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({gnt_pw, gnt_dly}) <= 1);                            // R7

    AST_PW_SERVED: assert property (@(posedge clk) disable iff (!rst_n)
        pw_vld |-> (gnt_pw || (|gnt_dly)));                             // R7

    AST_GNT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_dly & ~dly_vld) == '0);                                    // R7

    AST_RELEASE_GNT: assert property (@(posedge clk) disable iff (!rst_n)
        rd_release |-> (|gnt_dly));                                     // R5

    AST_TAG_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        acc_en |=> (acc_tag == TAG_W'($past(acc_tag) + TAG_W'(1))));    // R2

    AST_TAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_en |=> $stable(acc_tag));                                  // R2

    for (genvar i = 0; i < N_DLY; i++) begin : g_slot
        logic [TAG_W-1:0] gap;
        assign gap = pw_tag - dly_tag[i*TAG_W +: TAG_W];

        AST_NO_OVERTAKE: assert property (@(posedge clk) disable iff (!rst_n)
            (gnt_dly[i] && pw_vld && dly_kind[2*i +: 2] != 2'b11)
                |-> !gap[TAG_W-1]);                                     // R3
    end

endmodule

bind xbr_order_arb xbr_order_arb_chk #(.N_DLY(N_DLY), .TAG_W(TAG_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_en     (acc_en),
    .acc_tag    (acc_tag),
    .pw_vld     (pw_vld),
    .pw_tag     (pw_tag),
    .dly_vld    (dly_vld),
    .dly_tag    (dly_tag),
    .dly_kind   (dly_kind),
    .gnt_pw     (gnt_pw),
    .gnt_dly    (gnt_dly),
    .rd_release (rd_release)
);

// File: tb/tb_xbr_order_arb.sv
module tb_xbr_order_arb;

    localparam int N = 4;
    localparam int T = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             acc_en = 1'b0;
    logic [T-1:0]     acc_tag;
    logic             pw_vld = 1'b0;
    logic [T-1:0]     pw_tag = '0;
    logic [N-1:0]     dly_vld = '0;
    logic [N*T-1:0]   dly_tag = '0;
    logic [2*N-1:0]   dly_kind = '0;
    logic             launch = 1'b0;
    logic             gnt_pw;
    logic [N-1:0]     gnt_dly;
    logic             rd_release;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    xbr_order_arb #(.N_DLY(N), .TAG_W(T)) dut (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_tag(acc_tag),
        .pw_vld(pw_vld), .pw_tag(pw_tag), .dly_vld(dly_vld),
        .dly_tag(dly_tag), .dly_kind(dly_kind), .launch(launch),
        .gnt_pw(gnt_pw), .gnt_dly(gnt_dly), .rd_release(rd_release)
    );

    // exp = {gnt_pw, gnt_dly[3:0], rd_release}
    typedef struct packed {
        logic        pv;
        logic [3:0]  pt;
        logic [3:0]  dv;
        logic [15:0] dt;
        logic [7:0]  dk;
        logic [5:0]  exp;
    } vec_t;

    // Walked with the fairness state favouring the delayed side, rotation at slot 0.
    localparam vec_t VEC [13] = '{
        '{1'b0, 4'd0,  4'b0000, 16'h0000, 8'b00000000, 6'b0_0000_0}, // R7 idle
        '{1'b1, 4'd5,  4'b0000, 16'h0000, 8'b00000000, 6'b1_0000_0}, // R7 posted alone
        '{1'b1, 4'd2,  4'b0001, 16'h0003, 8'b00000000, 6'b1_0000_0}, // R3 read req held
        '{1'b1, 4'd2,  4'b0010, 16'h0030, 8'b00000100, 6'b1_0000_0}, // R4 write req held
        '{1'b1, 4'd2,  4'b0100, 16'h0300, 8'b00100000, 6'b1_0000_0}, // R5 read cpl held
        '{1'b1, 4'd6,  4'b1000, 16'h7000, 8'b11000000, 6'b0_1000_0}, // R6 write cpl passes
        '{1'b1, 4'd9,  4'b0010, 16'h0040, 8'b00000000, 6'b0_0010_0}, // R8 older read req wins turn
        '{1'b1, 4'd9,  4'b0100, 16'h0400, 8'b00100000, 6'b0_0100_1}, // R5 released
        '{1'b1, 4'd14, 4'b0001, 16'h0001, 8'b00000000, 6'b1_0000_0}, // R3 wrap, posted older
        '{1'b1, 4'd1,  4'b0001, 16'h000E, 8'b00000000, 6'b0_0001_0}, // R3 wrap, slot older
        '{1'b0, 4'd0,  4'b0111, 16'h0803, 8'b00100100, 6'b0_0001_0}, // R9 pointer at slot 0
        '{1'b1, 4'd5,  4'b0011, 16'h0027, 8'b00000100, 6'b0_0010_0}, // R9 skips held slot
        '{1'b0, 4'd0,  4'b1111, 16'h4321, 8'b10101010, 6'b0_0001_1}  // R5 four completions
    };

    task automatic chk(input string req, input logic [5:0] act, input logic [5:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    function automatic logic [5:0] outs();
        return {gnt_pw, gnt_dly, rd_release};
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; launch = 1'b0; acc_en = 1'b0;
        pw_vld = 1'b0; dly_vld = '0; dly_tag = '0; dly_kind = '0; pw_tag = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        #(20 * 100000);
        n_chk++; n_bad++;
        $display("FAIL R1 watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        do_reset();
        #2;
        chk("R1 reset outputs", outs(), 6'b0);
        chk("R1 reset tag", {2'b0, acc_tag}, 6'd0);

        // R2: tag steps on each accept and wraps.
        @(negedge clk); acc_en = 1'b1; dly_vld = 4'b1111;
        repeat (3) @(negedge clk);
        acc_en = 1'b0; #2;
        chk("R2 tag after three", {2'b0, acc_tag}, 6'd3);
        @(negedge clk); acc_en = 1'b1;
        repeat (13) @(negedge clk);
        acc_en = 1'b0; #2;
        chk("R2 tag wrap", {2'b0, acc_tag}, 6'd0);

        // One posted launch turns fairness toward the delayed side.
        do_reset();
        @(negedge clk); pw_vld = 1'b1; pw_tag = 4'd0; launch = 1'b1;
        @(negedge clk); launch = 1'b0; pw_vld = 1'b0;
        for (int v = 0; v < 13; v++) begin
            pw_vld = VEC[v].pv; pw_tag = VEC[v].pt; dly_vld = VEC[v].dv;
            dly_tag = VEC[v].dt; dly_kind = VEC[v].dk;
            #2;
            chk($sformatf("R3/R4/R5/R6/R7/R8/R9 vector %0d", v), outs(), VEC[v].exp);
            @(negedge clk);
        end

        // R8: alternation between posted and an eligible delayed slot.
        do_reset();
        @(negedge clk);
        pw_vld = 1'b1; pw_tag = 4'd9; dly_vld = 4'b0001; dly_tag = 16'h0004;
        dly_kind = 8'b0; launch = 1'b1; #2;
        chk("R8 first contest to posted", outs(), 6'b1_0000_0);
        @(negedge clk); #2;
        chk("R8 then delayed", outs(), 6'b0_0001_0);
        @(negedge clk); #2;
        chk("R8 then posted again", outs(), 6'b1_0000_0);
        @(negedge clk); launch = 1'b0; #2;
        chk("R8 state after launch", outs(), 6'b0_0001_0);
        @(negedge clk); #2;
        chk("R8 state held without launch", outs(), 6'b0_0001_0);

        // R9: rotation among delayed slots.
        do_reset();
        @(negedge clk);
        pw_vld = 1'b0; dly_vld = 4'b1011; dly_tag = 16'h3021; dly_kind = 8'b0;
        launch = 1'b1; #2;
        chk("R9 rotate slot0", outs(), 6'b0_0001_0);
        @(negedge clk); #2;
        chk("R9 rotate slot1", outs(), 6'b0_0010_0);
        @(negedge clk); #2;
        chk("R9 rotate slot3", outs(), 6'b0_1000_0);
        @(negedge clk); #2;
        chk("R9 rotate wraps to slot0", outs(), 6'b0_0001_0);
        @(negedge clk); launch = 1'b0;

        finish_run();
    end

endmodule